// File: doc/BRIEF.md
# DMA Descriptor Fetch Loader

This block loads a DMA channel's working registers from a descriptor held in memory. A start pulse, given when a channel is enabled or when a work unit ends, makes it capture the channel's present register values. It then reads a variable number of 16-bit descriptor words, one at a time, and overlays them onto those registers. The flow mode in the configuration sets how many words are read, where they come from and which registers they fill.

When the words are in, the block checks the loaded configuration. It then sets up the current descriptor pointer, the current address and the current X and Y counts, and raises a one-cycle done pulse. A bad flow mode, a descriptor size that the mode does not allow, or an element-size and stride mismatch raises a one-cycle configuration-error pulse instead. A misaligned start address is reported beside done on a separate error output. The block does not move any data.

Top module: `dsc_loader`

## Requirements
- R1: The configuration word holds the flow mode in bits 15:12 (0 stop, 1 autobuffer, 4 array, 6 small list, 7 large list), the descriptor word count in bits 11:8 and the word size in bits 3:2. The count must be 0 for stop and autobuffer, 1..7 for array, 1..8 for small and 1..9 for large. Any other count, or any other mode code, gives a cfg_err_o pulse with no memory read and no done_o.
- R2: In stop or autobuffer mode with a count of 0, no memory read is issued and done_o follows.
- R3: The fetch base is cur_ptr_i in array mode and next_ptr_i in small and large mode. Word i is read from base+2*i. Only one read is outstanding at a time, and rd_req_o is a one-cycle pulse.
- R4: In large mode the words fill, in order: next pointer low, next pointer high, start address low, start address high, config, X count, X modify, Y count, Y modify.
- R5: In small mode the first word fills the next pointer low half, and the later words fill the sequence from start address low onwards.
- R6: In array mode the first word fills the start address low half, and the later words follow the same sequence.
- R7: Any register half that is not among the fetched words keeps the value it had at the start pulse.
- R8: The element size is 1, 2 or 4 bytes for word-size codes 0, 1 and 2; code 3 is a configuration error. If the magnitude of X modify differs from the element size, cfg_err_o pulses and done_o does not. Both checks use the loaded values.
- R9: A loaded start address that is not a multiple of the element size asserts align_err_o together with done_o.
- R10: With done_o, cur_ptr_o equals the loaded next pointer and cur_addr_o equals the loaded start address. cur_x_o and cur_y_o equal the loaded counts, except that a zero count loads as 0xFFFF.
- R11: A start pulse while busy_o is high is ignored, and input changes during a fetch have no effect on the result.
- R12: done_o and cfg_err_o are one-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start load request |
| cfg_i | input | 16 | Present configuration register |
| next_ptr_i | input | AW | Present next descriptor pointer |
| cur_ptr_i | input | AW | Present current descriptor pointer |
| start_addr_i | input | AW | Present start address |
| x_count_i | input | 16 | Present X count |
| x_mod_i | input | 16 | Present X modify |
| y_count_i | input | 16 | Present Y count |
| y_mod_i | input | 16 | Present Y modify |
| rd_req_o | output | 1 | Word read request pulse |
| rd_addr_o | output | AW | Byte address of requested word |
| rd_valid_i | input | 1 | Read response valid |
| rd_data_i | input | 16 | Read response word |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Load complete pulse |
| cfg_err_o | output | 1 | Configuration error pulse |
| align_err_o | output | 1 | Misaligned start address, with done |
| next_ptr_o | output | AW | Loaded next descriptor pointer |
| start_addr_o | output | AW | Loaded start address |
| cfg_o | output | 16 | Loaded configuration |
| x_count_o | output | 16 | Loaded X count |
| x_mod_o | output | 16 | Loaded X modify |
| y_count_o | output | 16 | Loaded Y count |
| y_mod_o | output | 16 | Loaded Y modify |
| cur_ptr_o | output | AW | Current descriptor pointer |
| cur_addr_o | output | AW | Current address |
| cur_x_o | output | 16 | Current X count |
| cur_y_o | output | 16 | Current Y count |

## Verification
The bench probes the word-count limits of each flow mode at both edges, unknown mode codes, word-size code 3, negative and mismatched strides, and zero counts. A design with an off-by-one limit would read memory or report done on an illegal descriptor. A design without the zero substitution would report a current count of 0. The fetch tests check the per-mode word layout and the fetch base. A design that uses the wrong base pointer or shifts the layout by one word puts values into the wrong register halves, and a partial fetch shows whether untouched halves survive. A second start pulse and changed inputs during a fetch would corrupt a design that does not latch its inputs. A loaded configuration with an illegal word size checks that validation uses the fetched values.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam logic [3:0] FL_STOP  = 4'd0;
  localparam logic [3:0] FL_AUTO  = 4'd1;
  localparam logic [3:0] FL_ARRAY = 4'd4;
  localparam logic [3:0] FL_SMALL = 4'd6;
  localparam logic [3:0] FL_LARGE = 4'd7;

  localparam int FLOW_LSB = 12;
  localparam int NDS_LSB  = 8;
  localparam int WS_LSB   = 2;

  localparam logic [3:0] MAX_ARRAY = 4'd7;
  localparam logic [3:0] MAX_SMALL = 4'd8;
  localparam logic [3:0] MAX_LARGE = 4'd9;

  typedef enum logic [3:0] {
    SL_NDP_LO, SL_NDP_HI, SL_SA_LO, SL_SA_HI, SL_CFG,
    SL_XC, SL_XM, SL_YC, SL_YM
  } slot_e;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} seq_e;
endpackage

// File: rtl/dsc_flow_check.sv
module dsc_flow_check
  import dsc_pkg::*;
(
  input  logic [3:0] flow_i,
  input  logic [3:0] nds_i,
  output logic       ok_o
);
  always_comb begin
    unique case (flow_i)
      FL_STOP, FL_AUTO: ok_o = (nds_i == 4'd0);
      FL_ARRAY:         ok_o = (nds_i != 4'd0) && (nds_i <= MAX_ARRAY);
      FL_SMALL:         ok_o = (nds_i != 4'd0) && (nds_i <= MAX_SMALL);
      FL_LARGE:         ok_o = (nds_i != 4'd0) && (nds_i <= MAX_LARGE);
      default:          ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsc_elem_check.sv
module dsc_elem_check #(
  parameter int MW = 16
) (
  input  logic [1:0]    ws_i,
  input  logic [MW-1:0] xmod_i,
  input  logic [1:0]    addr_lo_i,
  output logic          ok_o,
  output logic          align_ok_o
);
  logic [MW-1:0] elem;
  logic [MW-1:0] neg_mod;
  logic [1:0]    mask;

  always_comb begin
    unique case (ws_i)
      2'd0:    begin elem = MW'(1); mask = 2'b00; end
      2'd1:    begin elem = MW'(2); mask = 2'b01; end
      2'd2:    begin elem = MW'(4); mask = 2'b11; end
      default: begin elem = '0;     mask = 2'b00; end
    endcase
    neg_mod    = '0 - xmod_i;
    ok_o       = (ws_i != 2'd3) && ((xmod_i == elem) || (neg_mod == elem));
    align_ok_o = (addr_lo_i & mask) == 2'b00;
  end
endmodule

// File: rtl/dsc_word_map.sv
module dsc_word_map
  import dsc_pkg::*;
(
  input  logic [3:0] flow_i,
  input  logic [3:0] idx_i,
  output slot_e      slot_o
);
  always_comb begin
    unique case (flow_i)
      FL_ARRAY: slot_o = slot_e'(idx_i + 4'd2);
      FL_SMALL: slot_o = (idx_i == 4'd0) ? SL_NDP_LO : slot_e'(idx_i + 4'd1);
      default:  slot_o = slot_e'(idx_i);
    endcase
  end
endmodule

// File: rtl/dsc_seq.sv
module dsc_seq
  import dsc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       start_ok_i,
  input  logic [3:0] nwords_i,
  input  logic       rd_valid_i,
  output logic       accept_o,
  output logic       start_err_o,
  output logic       req_o,
  output logic       store_o,
  output logic [3:0] idx_o,
  output logic       finish_o,
  output logic       busy_o
);
  seq_e       state_q;
  logic [3:0] idx_q, n_q;
  logic       err_q;

  assign accept_o    = (state_q == S_IDLE) && start_i && start_ok_i;
  assign req_o       = (state_q == S_REQ);
  assign store_o     = (state_q == S_WAIT) && rd_valid_i;
  assign finish_o    = (state_q == S_FIN);
  assign busy_o      = (state_q != S_IDLE);
  assign idx_o       = idx_q;
  assign start_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i && !start_ok_i) err_q <= 1'b1;
          if (accept_o) begin
            idx_q   <= '0;
            n_q     <= nwords_i;
            state_q <= (nwords_i == 4'd0) ? S_FIN : S_REQ;
          end
        end
        S_REQ: state_q <= S_WAIT;
        S_WAIT: begin
          if (rd_valid_i) begin
            if (idx_q == n_q - 4'd1) state_q <= S_FIN;
            else begin
              idx_q   <= idx_q + 4'd1;
              state_q <= S_REQ;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsc_loader.sv
module dsc_loader
  import dsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [15:0]   cfg_i,
  input  logic [AW-1:0] next_ptr_i,
  input  logic [AW-1:0] cur_ptr_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [CW-1:0] x_count_i,
  input  logic [CW-1:0] x_mod_i,
  input  logic [CW-1:0] y_count_i,
  input  logic [CW-1:0] y_mod_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [15:0]   rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          cfg_err_o,
  output logic          align_err_o,
  output logic [AW-1:0] next_ptr_o,
  output logic [AW-1:0] start_addr_o,
  output logic [15:0]   cfg_o,
  output logic [CW-1:0] x_count_o,
  output logic [CW-1:0] x_mod_o,
  output logic [CW-1:0] y_count_o,
  output logic [CW-1:0] y_mod_o,
  output logic [AW-1:0] cur_ptr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_x_o,
  output logic [CW-1:0] cur_y_o
);
  localparam int HB = AW / 2;
  localparam logic [CW-1:0] CNT_FULL = '1;

  logic [AW-1:0] nd_q, sa_q, base_q, cptr_q, caddr_q;
  logic [15:0]   cfg_q;
  logic [CW-1:0] xc_q, xm_q, yc_q, ym_q, cx_q, cy_q;
  logic [3:0]    flow_q;
  logic          done_q, ferr_q, align_q;

  logic       start_ok, accept, start_err, store, finish;
  logic [3:0] idx;
  slot_e      slot;
  logic       elem_ok, align_ok;

  dsc_flow_check u_flow (
    .flow_i (cfg_i[FLOW_LSB +: 4]),
    .nds_i  (cfg_i[NDS_LSB +: 4]),
    .ok_o   (start_ok)
  );

  dsc_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_ok_i  (start_ok),
    .nwords_i    (cfg_i[NDS_LSB +: 4]),
    .rd_valid_i  (rd_valid_i),
    .accept_o    (accept),
    .start_err_o (start_err),
    .req_o       (rd_req_o),
    .store_o     (store),
    .idx_o       (idx),
    .finish_o    (finish),
    .busy_o      (busy_o)
  );

  dsc_word_map u_map (
    .flow_i (flow_q),
    .idx_i  (idx),
    .slot_o (slot)
  );

  dsc_elem_check #(.MW(CW)) u_elem (
    .ws_i       (cfg_q[WS_LSB +: 2]),
    .xmod_i     (xm_q),
    .addr_lo_i  (sa_q[1:0]),
    .ok_o       (elem_ok),
    .align_ok_o (align_ok)
  );

  assign rd_addr_o = base_q + {{(AW-5){1'b0}}, idx, 1'b0};

  // working registers: captured on accept, overlaid by fetched words
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nd_q   <= '0;
      sa_q   <= '0;
      base_q <= '0;
      cfg_q  <= '0;
      flow_q <= '0;
      xc_q   <= '0;
      xm_q   <= '0;
      yc_q   <= '0;
      ym_q   <= '0;
    end else if (accept) begin
      nd_q   <= next_ptr_i;
      sa_q   <= start_addr_i;
      cfg_q  <= cfg_i;
      flow_q <= cfg_i[FLOW_LSB +: 4];
      xc_q   <= x_count_i;
      xm_q   <= x_mod_i;
      yc_q   <= y_count_i;
      ym_q   <= y_mod_i;
      base_q <= (cfg_i[FLOW_LSB +: 4] == FL_ARRAY) ? cur_ptr_i : next_ptr_i;
    end else if (store) begin
      unique case (slot)
        SL_NDP_LO: nd_q[HB-1:0]  <= rd_data_i[HB-1:0];
        SL_NDP_HI: nd_q[AW-1:HB] <= rd_data_i[AW-HB-1:0];
        SL_SA_LO:  sa_q[HB-1:0]  <= rd_data_i[HB-1:0];
        SL_SA_HI:  sa_q[AW-1:HB] <= rd_data_i[AW-HB-1:0];
        SL_CFG:    cfg_q         <= rd_data_i;
        SL_XC:     xc_q          <= CW'(rd_data_i);
        SL_XM:     xm_q          <= CW'(rd_data_i);
        SL_YC:     yc_q          <= CW'(rd_data_i);
        default:   ym_q          <= CW'(rd_data_i);
      endcase
    end
  end

  // completion: validate loaded values, set up current state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      align_q <= 1'b0;
      cptr_q  <= '0;
      caddr_q <= '0;
      cx_q    <= '0;
      cy_q    <= '0;
    end else begin
      done_q  <= 1'b0;
      ferr_q  <= 1'b0;
      align_q <= 1'b0;
      if (finish) begin
        if (elem_ok) begin
          done_q  <= 1'b1;
          align_q <= !align_ok;
          cptr_q  <= nd_q;
          caddr_q <= sa_q;
          cx_q    <= (xc_q == '0) ? CNT_FULL : xc_q;
          cy_q    <= (yc_q == '0) ? CNT_FULL : yc_q;
        end else begin
          ferr_q <= 1'b1;
        end
      end
    end
  end

  assign done_o       = done_q;
  assign cfg_err_o    = start_err | ferr_q;
  assign align_err_o  = align_q;
  assign next_ptr_o   = nd_q;
  assign start_addr_o = sa_q;
  assign cfg_o        = cfg_q;
  assign x_count_o    = xc_q;
  assign x_mod_o      = xm_q;
  assign y_count_o    = yc_q;
  assign y_mod_o      = ym_q;
  assign cur_ptr_o    = cptr_q;
  assign cur_addr_o   = caddr_q;
  assign cur_x_o      = cx_q;
  assign cur_y_o      = cy_q;
endmodule

// File: rtl/dsc_loader_chk.sv
module dsc_loader_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_req_o,
  input logic          rd_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          cfg_err_o,
  input logic          align_err_o,
  input logic [AW-1:0] next_ptr_o,
  input logic [AW-1:0] start_addr_o,
  input logic [AW-1:0] cur_ptr_o,
  input logic [AW-1:0] cur_addr_o,
  input logic [CW-1:0] cur_x_o,
  input logic [CW-1:0] cur_y_o
);
  logic outst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) outst_q <= 1'b0;
    else if (rd_req_o) outst_q <= 1'b1;
    else if (rd_valid_i) outst_q <= 1'b0;
  end

  a_r12_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && cfg_err_o));
  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !outst_q);
  a_r3_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  a_r10_no_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cur_x_o != '0) && (cur_y_o != '0));
  a_r10_cur_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cur_addr_o == start_addr_o) && (cur_ptr_o == next_ptr_o));
  a_r9_align_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> done_o);
  a_r11_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
endmodule

bind dsc_loader dsc_loader_chk #(.AW(AW), .CW(CW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_req_o     (rd_req_o),
  .rd_valid_i   (rd_valid_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .cfg_err_o    (cfg_err_o),
  .align_err_o  (align_err_o),
  .next_ptr_o   (next_ptr_o),
  .start_addr_o (start_addr_o),
  .cur_ptr_o    (cur_ptr_o),
  .cur_addr_o   (cur_addr_o),
  .cur_x_o      (cur_x_o),
  .cur_y_o      (cur_y_o)
);

// File: tb/test_dsc_loader.sv
module test_dsc_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg = '0;
  logic [31:0] np = '0, cp = '0, sa = '0;
  logic [15:0] xc = '0, xm = '0, yc = '0, ym = '0;
  logic        rd_req, rd_valid;
  logic [31:0] rd_addr;
  logic [15:0] rd_data;
  logic        busy, done, cerr, aerr;
  logic [31:0] nd_o, sa_o, cptr_o, caddr_o;
  logic [15:0] cfg_o, xc_o, xm_o, yc_o, ym_o, cx_o, cy_o;

  int checks = 0, fails = 0;
  int n_done, n_err, n_align, n_rd;
  logic [31:0] first_addr;
  logic summary_done = 1'b0;

  logic [15:0] mem [256];
  logic [7:0]  paddr;
  int          pend;

  always #2 clk = ~clk;

  dsc_loader i_dsc_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_i(cfg),
    .next_ptr_i(np), .cur_ptr_i(cp), .start_addr_i(sa),
    .x_count_i(xc), .x_mod_i(xm), .y_count_i(yc), .y_mod_i(ym),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .busy_o(busy), .done_o(done), .cfg_err_o(cerr), .align_err_o(aerr),
    .next_ptr_o(nd_o), .start_addr_o(sa_o), .cfg_o(cfg_o),
    .x_count_o(xc_o), .x_mod_o(xm_o), .y_count_o(yc_o), .y_mod_o(ym_o),
    .cur_ptr_o(cptr_o), .cur_addr_o(caddr_o), .cur_x_o(cx_o), .cur_y_o(cy_o)
  );

  // memory responder: two cycles of latency
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0; rd_data <= '0; pend <= 0; paddr <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) begin rd_valid <= 1'b1; rd_data <= mem[paddr]; end
      end
      if (rd_req) begin pend <= 2; paddr <= rd_addr[8:1]; end
    end
  end

  always @(negedge clk) begin
    if (done) n_done++;
    if (cerr) n_err++;
    if (aerr) n_align++;
    if (rd_req) begin
      if (n_rd == 0) first_addr = rd_addr;
      n_rd++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] c, input logic [31:0] n, input logic [31:0] p,
                     input logic [31:0] s, input logic [15:0] x, input logic [15:0] xmd,
                     input logic [15:0] y, input logic [15:0] ymd);
    @(negedge clk);
    n_done = 0; n_err = 0; n_align = 0; n_rd = 0; first_addr = '0;
    cfg = c; np = n; cp = p; sa = s; xc = x; xm = xmd; yc = y; ym = ymd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (n_done != 0 || n_err != 0) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] c;
    logic [31:0] s;
    logic [15:0] x, xmd, y;
    logic        err, al;
    logic [15:0] ex, ey;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{16'h0004, 32'h10, 16'd8, 16'h0002, 16'd3, 1'b0, 1'b0, 16'd8,    16'd3},    // R2 stop
    '{16'h1008, 32'h20, 16'd0, 16'hFFFC, 16'd0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF}, // R2 R10 auto, zero counts
    '{16'h0104, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R1 stop size 1
    '{16'h4004, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R1 array size 0
    '{16'h4804, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R1 array size 8
    '{16'h6904, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R1 small size 9
    '{16'h7A04, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R1 large size 10
    '{16'h2004, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R1 unknown mode
    '{16'h000C, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R8 word size 3
    '{16'h0000, 32'h10, 16'd1, 16'h0002, 16'd1, 1'b1, 1'b0, 16'd0,    16'd0},    // R8 stride mismatch
    '{16'h1008, 32'h22, 16'd1, 16'h0004, 16'd1, 1'b0, 1'b1, 16'd1,    16'd1},    // R9 misaligned
    '{16'h0000, 32'h07, 16'd5, 16'hFFFF, 16'd0, 1'b0, 1'b0, 16'd5,    16'hFFFF}  // R8 R10 byte, negative
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cerr && !aerr && !rd_req, "reset idle", {busy, done, cerr, aerr, rd_req}, 0);
    chk(cptr_o == 0 && cx_o == 0, "reset cur", cptr_o, 0);
    rst_n = 1'b1;

    foreach (VECS[k]) begin
      run(VECS[k].c, 32'h8000, 32'h9000, VECS[k].s, VECS[k].x, VECS[k].xmd, VECS[k].y, 16'h1234);
      chk(n_rd == 0, "R1 R2 no reads", n_rd, 0);
      chk(n_err == (VECS[k].err ? 1 : 0), "R1 R8 cfg_err", n_err, VECS[k].err);
      chk(n_done == (VECS[k].err ? 0 : 1), "R12 done count", n_done, !VECS[k].err);
      chk(n_align == (VECS[k].al ? 1 : 0), "R9 align", n_align, VECS[k].al);
      if (!VECS[k].err) begin
        chk(cptr_o == 32'h8000 && caddr_o == VECS[k].s, "R10 cur ptr/addr", caddr_o, VECS[k].s);
        chk(cx_o == VECS[k].ex, "R10 cur x", cx_o, VECS[k].ex);
        chk(cy_o == VECS[k].ey, "R10 cur y", cy_o, VECS[k].ey);
      end
    end

    // R4 large list, full descriptor
    mem[8'h20] = 16'h0080; mem[8'h21] = 16'h0000; mem[8'h22] = 16'h1000;
    mem[8'h23] = 16'h0002; mem[8'h24] = 16'h7904; mem[8'h25] = 16'h0000;
    mem[8'h26] = 16'h0002; mem[8'h27] = 16'h0005; mem[8'h28] = 16'hFFFE;
    run(16'h7904, 32'h40, 32'h9000, 32'hFFFF_FFFF, 16'd1, 16'd2, 16'd1, 16'd0);
    chk(n_rd == 9 && first_addr == 32'h40, "R3 large reads/base", first_addr, 32'h40);
    chk(n_done == 1 && n_err == 0 && n_align == 0, "R4 large done", n_done, 1);
    chk(nd_o == 32'h80 && sa_o == 32'h0002_1000, "R4 large ptr/addr", sa_o, 32'h0002_1000);
    chk(cfg_o == 16'h7904 && xc_o == 16'h0 && xm_o == 16'h2, "R4 large cfg/x", {cfg_o, xc_o}, {16'h7904, 16'h0});
    chk(yc_o == 16'h5 && ym_o == 16'hFFFE, "R4 large y", {yc_o, ym_o}, {16'h5, 16'hFFFE});
    chk(cptr_o == 32'h80 && caddr_o == 32'h0002_1000, "R10 large cur", caddr_o, 32'h0002_1000);
    chk(cx_o == 16'hFFFF && cy_o == 16'h5, "R10 large counts", {cx_o, cy_o}, {16'hFFFF, 16'h5});

    // R5 small list, partial; R11 second start and input changes while busy
    mem[8'h80] = 16'h0200; mem[8'h81] = 16'h3004; mem[8'h82] = 16'h0001;
    fork
      run(16'h6308, 32'h0005_0100, 32'h9000, 32'hAAAA_0000, 16'd7, 16'd4, 16'd2, 16'd8);
      begin
        repeat (5) @(negedge clk);
        cfg = 16'h0000; sa = 32'h1; xm = 16'h1; np = 32'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(n_rd == 3 && first_addr == 32'h0005_0100, "R3 small reads/base", first_addr, 32'h0005_0100);
    chk(n_done == 1 && n_err == 0, "R11 single done", n_done, 1);
    chk(nd_o == 32'h0005_0200, "R5 R7 small next ptr", nd_o, 32'h0005_0200);
    chk(sa_o == 32'h0001_3004, "R5 small start addr", sa_o, 32'h0001_3004);
    chk(cfg_o == 16'h6308 && xm_o == 16'h4 && ym_o == 16'h8, "R7 small kept", {cfg_o, xm_o}, {16'h6308, 16'h4});
    chk(cx_o == 16'd7 && cy_o == 16'd2 && cptr_o == 32'h0005_0200, "R10 small cur", {cx_o, cy_o}, {16'd7, 16'd2});

    // R6 array mode from the current pointer, misaligned result
    mem[8'hC0] = 16'h0003; mem[8'hC1] = 16'h0000;
    run(16'h4204, 32'h1234_0000, 32'h180, 32'h5555_5555, 16'd3, 16'hFFFE, 16'd4, 16'd0);
    chk(n_rd == 2 && first_addr == 32'h180, "R3 array reads/base", first_addr, 32'h180);
    chk(sa_o == 32'h3 && nd_o == 32'h1234_0000, "R6 array layout", sa_o, 32'h3);
    chk(n_done == 1 && n_align == 1, "R9 array misaligned", n_align, 1);
    chk(cptr_o == 32'h1234_0000 && caddr_o == 32'h3, "R10 array cur", cptr_o, 32'h1234_0000);

    // R8 loaded config carries an illegal word size
    mem[8'hD0] = 16'h0300; mem[8'hD1] = 16'h0000; mem[8'hD2] = 16'h0010;
    mem[8'hD3] = 16'h0000; mem[8'hD4] = 16'h750C;
    run(16'h7504, 32'h1A0, 32'h9000, 32'h0, 16'd1, 16'd2, 16'd1, 16'd0);
    chk(n_rd == 5, "R8 loaded reads", n_rd, 5);
    chk(n_err == 1 && n_done == 0, "R8 loaded cfg error", n_err, 1);

    if (!summary_done) begin
      summary_done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!summary_done) begin
      summary_done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule